// File: doc/BRIEF.md
# Flag-Selected Inverse Word Decoder

This block sits at the receive end of a low-transition serial link. The sender sends each data word in one of four forms, whichever has the fewest bit toggles. It also sends a 2-bit flag that names the chosen form. The decoder takes the received code word and its flag, applies the matching inverse transform, and returns the original word.

There are four inverse paths. The first passes the word through unchanged. The second applies one Gray-to-binary conversion. The third first undoes a swap of two bits inside each nibble and then applies one Gray-to-binary conversion. The fourth applies two Gray-to-binary conversions one after the other. The flag chooses the path through a multiplexer. The result is registered, so each decoded word appears one clock after its input strobe, and a new word can be accepted on every cycle.

Top module: `wdec_top`

## Requirements
- R1: While `rstN` is low, and on the first clock edge after it rises with no strobe, `outValid` is 0 and `outWord` is 8'h00.
- R2: Flag value 2'b00 passes the code word through unchanged to `outWord`.
- R3: Flag value 2'b01 applies one Gray-to-binary conversion. Bit 7 of the result equals bit 7 of the input. Each lower result bit i is the XOR of result bit i+1 and input bit i (for example, 8'hED gives 8'hB6, and 8'h80 gives 8'hFF).
- R4: Flag value 2'b10 first splits the word into nibbles. Inside each nibble it exchanges bit 3 and bit 1 when they differ. It then applies one Gray-to-binary conversion. For example, 8'hE7 becomes 8'hED after the exchange and 8'hB6 at the output, and 8'h08 gives 8'h03.
- R5: Flag value 2'b11 applies two Gray-to-binary conversions in a row. For example, 8'h80 gives 8'hAA.
- R6: A word strobed with `inValid` high at a clock edge appears on `outWord`, with `outValid` high, right after that edge. Strobes on consecutive cycles each produce their own output on consecutive cycles.
- R7: A clock edge with `inValid` low drives `outValid` low and leaves `outWord` unchanged, whatever the code word and flag inputs hold.
- R8: For every 8-bit word and every flag, decoding the sender's forward transform for that flag returns the original word. When the sender picks the form with the fewest toggles, that form never has more toggles than the raw word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Strobe: code word and flag are valid this cycle |
| inFlag | input | 2 | Selects which inverse path to apply |
| inWord | input | 8 | Received code word |
| outValid | output | 1 | Decoded word valid, one cycle after the strobe |
| outWord | output | 8 | Registered decoded word |

## Verification
The bench builds the block with its default 8-bit word and 4-bit nibble. At that size it can try every one of the 256 words under all four flags, each passed through a forward model of the sender and then back through the decoder. A hand-worked vector table checks each path on known words, including the case where a nibble exchange fires and the case where it does not. Directed sequences then cover reset in the middle of operation, idle cycles with busy inputs, and strobes on consecutive cycles.

// File: rtl/wdec_pkg.sv
package wdec_pkg;

  typedef enum logic [1:0] {
    FLAG_RAW      = 2'b00,
    FLAG_GRAY1    = 2'b01,
    FLAG_SWAPGRAY = 2'b10,
    FLAG_GRAY2    = 2'b11
  } flag_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;       // capture a new decoded word
    logic useGray;    // take a Gray-decoded path instead of raw
    logic useUnswap;  // undo the nibble exchange before decoding
    logic useSecond;  // take the doubly decoded result
  } pathCtl_t;

endpackage

// File: rtl/wdec_gray_stage.sv
module wdec_gray_stage #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] grayIn,
  output logic [WIDTH-1:0] binOut
);

  // Running XOR from the MSB down: each bit folds in the one above it
  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      acc       = acc ^ grayIn[i];
      binOut[i] = acc;
    end
  end

endmodule

// File: rtl/wdec_ctrl.sv
module wdec_ctrl
  import wdec_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  flag_e    inFlag,
  output pathCtl_t ctl,
  output logic     outValid
);

  always_comb begin
    ctl.load      = inValid;
    ctl.useGray   = (inFlag != FLAG_RAW);
    ctl.useUnswap = (inFlag == FLAG_SWAPGRAY);
    ctl.useSecond = (inFlag == FLAG_GRAY2);
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R1: valid is clear on the first edge after reset release
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !outValid);

  // R6: every strobe yields a valid output on the next cycle
  a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

endmodule

// File: rtl/wdec_path.sv
module wdec_path
  import wdec_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtl_t          ctl,
  input  logic [WORD_W-1:0] inWord,
  output logic [WORD_W-1:0] outWord
);

  localparam int NUM_NIB = WORD_W / NIB_W;
  localparam int HI_POS  = NIB_W - 1;  // first bit of a nibble, MSB side
  localparam int LO_POS  = NIB_W - 3;  // third bit of a nibble

  logic [WORD_W-1:0] swapWord;
  logic [WORD_W-1:0] stageIn;
  logic [WORD_W-1:0] onceWord;
  logic [WORD_W-1:0] twiceWord;
  logic [WORD_W-1:0] nextWord;

  // Nibble exchange: bits that differ are swapped, which is its own inverse
  for (genvar gi = 0; gi < NUM_NIB; gi++) begin : g_nib
    localparam int BASE = gi * NIB_W;
    logic [NIB_W-1:0] rawNib;
    logic [NIB_W-1:0] fixNib;
    assign rawNib = inWord[BASE +: NIB_W];
    always_comb begin
      fixNib = rawNib;
      if (rawNib[HI_POS] != rawNib[LO_POS]) begin
        fixNib[HI_POS] = rawNib[LO_POS];
        fixNib[LO_POS] = rawNib[HI_POS];
      end
    end
    assign swapWord[BASE +: NIB_W] = fixNib;
  end

  assign stageIn = ctl.useUnswap ? swapWord : inWord;

  wdec_gray_stage #(.WIDTH(WORD_W)) u_first (
    .grayIn (stageIn),
    .binOut (onceWord)
  );

  wdec_gray_stage #(.WIDTH(WORD_W)) u_second (
    .grayIn (onceWord),
    .binOut (twiceWord)
  );

  always_comb begin
    if (!ctl.useGray)      nextWord = inWord;
    else if (ctl.useSecond) nextWord = twiceWord;
    else                   nextWord = onceWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         outWord <= '0;
    else if (ctl.load) outWord <= nextWord;
  end

  // R2: raw path returns the input word intact
  a_r2_raw_pass: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && !ctl.useGray) |=> outWord == $past(inWord));

  // R3 / R5: Gray decoding keeps the most significant bit
  a_r3_msb_kept: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.useGray && !ctl.useUnswap)
      |=> outWord[WORD_W-1] == $past(inWord[WORD_W-1]));

  // R7: no strobe, no change
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(outWord));

endmodule

// File: rtl/wdec_top.sv
module wdec_top
  import wdec_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        inFlag,
  input  logic [WORD_W-1:0] inWord,
  output logic              outValid,
  output logic [WORD_W-1:0] outWord
);

  pathCtl_t ctl;

  wdec_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inFlag   (flag_e'(inFlag)),
    .ctl      (ctl),
    .outValid (outValid)
  );

  wdec_path #(.WORD_W(WORD_W), .NIB_W(NIB_W)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .inWord  (inWord),
    .outWord (outWord)
  );

  // R7: an idle edge leaves valid low at the port
  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: tb/tb_wdec_top.sv
module tb_wdec_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [1:0] inFlag = 2'b00;
  logic [7:0] inWord = 8'h00;
  logic       outValid;
  logic [7:0] outWord;

  int errCount = 0;
  int chkCount = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  wdec_top dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFlag(inFlag),
    .inWord(inWord), .outValid(outValid), .outWord(outWord)
  );

  // {flag, code word, expected}
  localparam logic [17:0] VEC [10] = '{
    {2'b00, 8'hA5, 8'hA5},  // R2
    {2'b00, 8'hFF, 8'hFF},  // R2
    {2'b01, 8'hED, 8'hB6},  // R3
    {2'b01, 8'h80, 8'hFF},  // R3
    {2'b01, 8'h01, 8'h01},  // R3
    {2'b10, 8'hE7, 8'hB6},  // R4 exchange fires in low nibble
    {2'b10, 8'h0A, 8'h0C},  // R4 bits equal, no exchange
    {2'b10, 8'h08, 8'h03},  // R4
    {2'b11, 8'h80, 8'hAA},  // R5
    {2'b11, 8'h00, 8'h00}   // R5
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    chkCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive on falling edge, captured at rising edge, sampled at next falling edge
  task automatic apply(input logic [1:0] f, input logic [7:0] w);
    inValid = 1'b1; inFlag = f; inWord = w;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  function automatic logic [7:0] toGray(input logic [7:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [7:0] nibSwap(input logic [7:0] w);
    logic [7:0] r;
    r = w;
    for (int n = 0; n < 2; n++) begin
      r[n*4+3] = w[n*4+1];
      r[n*4+1] = w[n*4+3];
    end
    return r;
  endfunction

  function automatic logic [7:0] encode(input logic [1:0] f, input logic [7:0] b);
    case (f)
      2'b00:   return b;
      2'b01:   return toGray(b);
      2'b10:   return nibSwap(toGray(b));
      default: return toGray(toGray(b));
    endcase
  endfunction

  function automatic int toggles(input logic [7:0] w);
    int t = 0;
    for (int i = 0; i < 7; i++) if (w[i] != w[i+1]) t++;
    return t;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {7'd0, outValid}, 8'h00);
    check("R1 reset word", outWord, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 post-release valid", {7'd0, outValid}, 8'h00);
    check("R1 post-release word", outWord, 8'h00);

    for (int k = 0; k < 10; k++) begin
      apply(VEC[k][17:16], VEC[k][15:8]);
      check("R6 valid after strobe", {7'd0, outValid}, 8'h01);
      check($sformatf("R2-R5 vector %0d", k), outWord, VEC[k][7:0]);
    end

    // R7: idle cycle with busy inputs
    apply(2'b01, 8'hED);
    inFlag = 2'b11; inWord = 8'h5A;
    @(negedge clk);
    check("R7 idle valid low", {7'd0, outValid}, 8'h00);
    check("R7 idle word held", outWord, 8'hB6);

    // R6: back-to-back strobes
    inValid = 1'b1; inFlag = 2'b11; inWord = 8'h80;
    @(negedge clk);
    check("R6 first of pair", outWord, 8'hAA);
    inFlag = 2'b10; inWord = 8'h08;
    @(negedge clk);
    inValid = 1'b0;
    check("R6 second valid", {7'd0, outValid}, 8'h01);
    check("R6 second of pair", outWord, 8'h03);

    // R1: reset in mid-operation clears state
    apply(2'b00, 8'h3C);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 mid reset valid", {7'd0, outValid}, 8'h00);
    check("R1 mid reset word", outWord, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    // R8: exhaustive round trip on every path, and least-toggle selection
    for (int w = 0; w < 256; w++) begin
      int best;
      logic [1:0] bestFlag;
      best = 99; bestFlag = 2'b00;
      for (int f = 0; f < 4; f++) begin
        logic [7:0] code;
        code = encode(f[1:0], w[7:0]);
        if (toggles(code) < best) begin best = toggles(code); bestFlag = f[1:0]; end
        apply(f[1:0], code);
        check($sformatf("R8 round trip flag %0d", f), outWord, w[7:0]);
      end
      check("R8 toggles not raised", 8'(best > toggles(w[7:0])), 8'h00);
      apply(bestFlag, encode(bestFlag, w[7:0]));
      check("R8 best form decodes", outWord, w[7:0]);
    end

    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        errCount++;
        chkCount++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end

endmodule